// File: doc/BRIEF.md
# Eight-bit ALU with carry, negative and zero flags

This block is the arithmetic core of a small accumulator datapath. It holds two operand registers, A and B, and three status flip-flops: carry (C), negative/overflow (N) and zero (Z). When an ALU instruction is issued, a 4-bit function code selects one of sixteen operations on A, B and C. A destination select bit writes the result back into A or into B, and all three flags are updated together.

The same code space covers plain moves, complements, increments and decrements of either operand, as well as add, subtract, logic and rotate operations. When no ALU instruction is issued, the surrounding datapath can still change the carry through a 2-bit carry command, or load A or B through a plain write port. N and Z only ever change on an ALU instruction.

Top module: `alu8_flag_unit`

## Requirements
- R1: After reset, A, B, C, N and Z are all zero.
- R2: Function 0000 yields A, 0001 yields the bitwise inverse of A, 0010 yields B and 0011 yields the bitwise inverse of B; each of these clears C.
- R3: Function 0100 yields A + B + C modulo 2^W. C takes the carry out of the top bit, and N is set on signed overflow (both operands share a sign that differs from the result's sign).
- R4: Function 0101 yields A − B − C modulo 2^W. C is set when the true difference is negative (a borrow), and N is set on signed overflow (the operands differ in sign and the result's sign differs from A's).
- R5: Function 0110 yields A AND B and 0111 yields A OR B; both clear C.
- R6: Function 1000 rotates A right by one and 1001 rotates A left by one, both clearing C. Function 1010 shifts A right with old C entering the top bit, and 1011 shifts A left with old C entering bit 0; in both, the bit shifted out becomes the new C.
- R7: Function 1100 gives A+1, 1101 gives A−1, 1110 gives B+1 and 1111 gives B−1, all modulo 2^W. C is set on wrap (increment from all ones, decrement from zero).
- R8: On every ALU instruction, Z is set exactly when the W-bit result is zero. For every function except 0100 and 0101, N equals the result's top bit.
- R9: With the destination select at 0, the result is written to A and B is unchanged. With it at 1, the result is written to B and A is unchanged.
- R10: When no ALU instruction is issued, a carry command sets C to 0 (code 00), to 1 (code 01), to its inverse (code 10) or to the external bit (code 11). N, Z, A and B stay unchanged.
- R11: When no ALU instruction is issued, the write port loads its data into A (select 0) or into B (select 1), and leaves the flags unchanged.
- R12: An ALU instruction takes precedence: in the same cycle, a carry command and a register write are ignored.
- R13: With no ALU instruction, no carry command and no write, all five state bits and registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alu_en | input | 1 | Issue an ALU instruction this cycle |
| dst_sel | input | 1 | Result destination: 0 = A, 1 = B |
| func | input | 4 | ALU function code |
| cmd_en | input | 1 | Apply a carry command this cycle |
| cmd | input | 2 | Carry command: 00 clear, 01 set, 10 invert, 11 load ext_bit |
| ext_bit | input | 1 | External bit for the carry-load command |
| wr_en | input | 1 | Load wr_data into a register |
| wr_sel | input | 1 | Write target: 0 = A, 1 = B |
| wr_data | input | W | Data for the write port |
| reg_a | output | W | Register A |
| reg_b | output | W | Register B |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative/overflow flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench builds the block with its default width W = 8. At that width the signed-overflow edges (0x7F/0x80), the wrap points (0x00/0xFF) and rotations through the carry can all be reached with directed operands. A random run then spreads all sixteen functions, both destinations and the colliding carry and write requests across the full operand space.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    F_PASS_A = 4'h0, F_NOT_A  = 4'h1, F_PASS_B = 4'h2, F_NOT_B  = 4'h3,
    F_ADD    = 4'h4, F_SUB    = 4'h5, F_AND    = 4'h6, F_OR     = 4'h7,
    F_ROR    = 4'h8, F_ROL    = 4'h9, F_RORC   = 4'hA, F_ROLC   = 4'hB,
    F_INC_A  = 4'hC, F_DEC_A  = 4'hD, F_INC_B  = 4'hE, F_DEC_B  = 4'hF
  } func_e;

  typedef enum logic [1:0] {
    C_CLR = 2'b00, C_SET = 2'b01, C_TGL = 2'b10, C_EXT = 2'b11
  } carry_cmd_e;

endpackage

// File: rtl/alu8_reset_sync.sv
module alu8_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/alu8_func_core.sv
module alu8_func_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  input  logic [3:0]   func,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         nout
);
  localparam int WX = W + 1;

  logic [WX-1:0] ext_a, ext_b, ext_c, wide;
  logic          is_arith;

  assign ext_a = {1'b0, opa};
  assign ext_b = {1'b0, opb};
  assign ext_c = {{W{1'b0}}, cin};

  always_comb begin
    wide     = '0;
    res      = '0;
    cout     = 1'b0;
    is_arith = 1'b0;
    unique case (func_e'(func))
      F_PASS_A: res = opa;
      F_NOT_A:  res = ~opa;
      F_PASS_B: res = opb;
      F_NOT_B:  res = ~opb;
      F_ADD: begin
        wide = ext_a + ext_b + ext_c;
        {cout, res} = wide;
        is_arith = 1'b1;
      end
      F_SUB: begin
        wide = ext_a - ext_b - ext_c;
        {cout, res} = wide;
        is_arith = 1'b1;
      end
      F_AND:    res = opa & opb;
      F_OR:     res = opa | opb;
      F_ROR:    res = {opa[0], opa[W-1:1]};
      F_ROL:    res = {opa[W-2:0], opa[W-1]};
      F_RORC: begin
        res  = {cin, opa[W-1:1]};
        cout = opa[0];
      end
      F_ROLC: begin
        res  = {opa[W-2:0], cin};
        cout = opa[W-1];
      end
      F_INC_A: begin wide = ext_a + 1'b1; {cout, res} = wide; end
      F_DEC_A: begin wide = ext_a - 1'b1; {cout, res} = wide; end
      F_INC_B: begin wide = ext_b + 1'b1; {cout, res} = wide; end
      F_DEC_B: begin wide = ext_b - 1'b1; {cout, res} = wide; end
      default: res = '0;
    endcase
  end

  // signed overflow for add/sub, sign bit otherwise
  always_comb begin
    nout = res[W-1];
    if (is_arith) begin
      if (func_e'(func) == F_ADD)
        nout = (opa[W-1] == opb[W-1]) && (res[W-1] != opa[W-1]);
      else
        nout = (opa[W-1] != opb[W-1]) && (res[W-1] != opa[W-1]);
    end
  end
endmodule

// File: rtl/alu8_carry_ctl.sv
module alu8_carry_ctl
  import alu8_pkg::*;
(
  input  logic [1:0] cmd,
  input  logic       c_now,
  input  logic       ext_bit,
  output logic       c_cmd
);
  always_comb begin
    unique case (carry_cmd_e'(cmd))
      C_CLR:   c_cmd = 1'b0;
      C_SET:   c_cmd = 1'b1;
      C_TGL:   c_cmd = ~c_now;
      C_EXT:   c_cmd = ext_bit;
      default: c_cmd = c_now;
    endcase
  end
endmodule

// File: rtl/alu8_state_regs.sv
module alu8_state_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alu_en,
  input  logic         dst_sel,
  input  logic [W-1:0] alu_res,
  input  logic         alu_c,
  input  logic         alu_n,
  input  logic         cmd_en,
  input  logic         c_cmd,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic         c_q,
  output logic         n_q,
  output logic         z_q
);
  logic [W-1:0] a_d, b_d;
  logic         c_d, n_d, z_d;
  logic         upd_en;

  assign upd_en = alu_en | cmd_en | wr_en;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    c_d = c_q;
    n_d = n_q;
    z_d = z_q;
    if (alu_en) begin
      if (dst_sel) b_d = alu_res;
      else         a_d = alu_res;
      c_d = alu_c;
      n_d = alu_n;
      z_d = ~|alu_res;
    end else begin
      if (cmd_en) c_d = c_cmd;
      if (wr_en) begin
        if (wr_sel) b_d = wr_data;
        else        a_d = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= 1'b0;
      n_q <= 1'b0;
      z_q <= 1'b0;
    end else if (upd_en) begin
      a_q <= a_d;
      b_q <= b_d;
      c_q <= c_d;
      n_q <= n_d;
      z_q <= z_d;
    end
  end
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alu_en,
  input  logic         dst_sel,
  input  logic [3:0]   func,
  input  logic         cmd_en,
  input  logic [1:0]   cmd,
  input  logic         ext_bit,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_b,
  output logic         flag_c,
  output logic         flag_n,
  output logic         flag_z
);
  logic         rst_sync_n;
  logic [W-1:0] core_res;
  logic         core_c, core_n, cmd_c;

  alu8_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alu8_func_core #(.W(W)) u_core (
    .opa  (reg_a),
    .opb  (reg_b),
    .cin  (flag_c),
    .func (func),
    .res  (core_res),
    .cout (core_c),
    .nout (core_n)
  );

  alu8_carry_ctl u_cctl (
    .cmd     (cmd),
    .c_now   (flag_c),
    .ext_bit (ext_bit),
    .c_cmd   (cmd_c)
  );

  alu8_state_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .alu_en  (alu_en),
    .dst_sel (dst_sel),
    .alu_res (core_res),
    .alu_c   (core_c),
    .alu_n   (core_n),
    .cmd_en  (cmd_en),
    .c_cmd   (cmd_c),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .a_q     (reg_a),
    .b_q     (reg_b),
    .c_q     (flag_c),
    .n_q     (flag_n),
    .z_q     (flag_z)
  );
endmodule

// File: rtl/alu8_flag_unit_chk.sv
module alu8_flag_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         alu_en,
  input logic         dst_sel,
  input logic         cmd_en,
  input logic [1:0]   cmd,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic         flag_c,
  input logic         flag_n,
  input logic         flag_z
);
  AST_DST_B_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && dst_sel) |=> $stable(reg_a)); // R9
  AST_DST_A_KEEPS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !dst_sel) |=> $stable(reg_b)); // R9
  AST_ZERO_TRACKS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_en && !dst_sel) |=> (flag_z == (reg_a == '0))); // R8
  AST_NZ_ONLY_ON_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_en |=> ($stable(flag_n) && $stable(flag_z))); // R10
  AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_en && cmd_en && cmd == 2'b01) |=> flag_c); // R10
  AST_CARRY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_en && cmd_en && cmd == 2'b10) |=> (flag_c != $past(flag_c))); // R10
  AST_WRITE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_en && wr_en && !wr_sel) |=> (reg_a == $past(wr_data))); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_en && !cmd_en && !wr_en) |=>
      ($stable(reg_a) && $stable(reg_b) && $stable(flag_c))); // R13
endmodule

bind alu8_flag_unit alu8_flag_unit_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .alu_en  (alu_en),
  .dst_sel (dst_sel),
  .cmd_en  (cmd_en),
  .cmd     (cmd),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .reg_a   (reg_a),
  .reg_b   (reg_b),
  .flag_c  (flag_c),
  .flag_n  (flag_n),
  .flag_z  (flag_z)
);

// File: tb/test_alu8_flag_unit.sv
`timescale 1ns/1ps
module test_alu8_flag_unit;
  localparam int W    = 8;
  localparam int MOD  = 1 << W;
  localparam int MASK = MOD - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         alu_en, dst_sel, cmd_en, ext_bit, wr_en, wr_sel;
  logic [3:0]   func;
  logic [1:0]   cmd;
  logic [W-1:0] wr_data, reg_a, reg_b;
  logic         flag_c, flag_n, flag_z;

  always #2.5 clk = ~clk;

  alu8_flag_unit #(.W(W)) i_alu8_flag_unit (
    .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .dst_sel(dst_sel), .func(func),
    .cmd_en(cmd_en), .cmd(cmd), .ext_bit(ext_bit), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .reg_a(reg_a), .reg_b(reg_b), .flag_c(flag_c),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  typedef struct {
    int    a, b;
    bit    c, n, z;
    string tag;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 0;

  // bench reference state
  int m_a = 0, m_b = 0;
  bit m_c = 0, m_n = 0, m_z = 0;

  function automatic void compare(exp_t e);
    vectors++;
    if (int'(reg_a) != e.a || int'(reg_b) != e.b || flag_c != e.c ||
        flag_n != e.n || flag_z != e.z) begin
      miscompares++;
      $display("FAIL %s: got A=%02h B=%02h C=%0d N=%0d Z=%0d, expected A=%02h B=%02h C=%0d N=%0d Z=%0d",
               e.tag, reg_a, reg_b, flag_c, flag_n, flag_z, e.a, e.b, e.c, e.n, e.z);
    end
  endfunction

  // monitor: one item per clock edge after the driver queued it
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  function automatic string tag_of(int f);
    case (f)
      0, 1, 2, 3:     return "R2";
      4:              return "R3";
      5:              return "R4";
      6, 7:           return "R5";
      8, 9, 10, 11:   return "R6";
      default:        return "R7";
    endcase
  endfunction

  // reference model of one ALU operation on the bench state
  task automatic model_alu(input int f, input bit ds);
    int r, t, sa, sb, sr;
    bit co, no;
    co = 0; no = 0; r = 0;
    case (f)
      0: r = m_a;
      1: r = MASK - m_a;
      2: r = m_b;
      3: r = MASK - m_b;
      4: begin t = m_a + m_b + int'(m_c); r = t % MOD; co = (t >= MOD); end
      5: begin t = m_a - m_b - int'(m_c); co = (t < 0); r = (t + MOD) % MOD; end
      6: r = m_a & m_b;
      7: r = m_a | m_b;
      8: r = (m_a / 2) + (m_a % 2) * (MOD / 2);
      9: r = ((m_a * 2) % MOD) + (m_a / (MOD / 2));
      10: begin r = (m_a / 2) + int'(m_c) * (MOD / 2); co = (m_a % 2) == 1; end
      11: begin r = ((m_a * 2) % MOD) + int'(m_c); co = m_a >= MOD / 2; end
      12: begin r = (m_a + 1) % MOD; co = (m_a == MASK); end
      13: begin r = (m_a + MASK) % MOD; co = (m_a == 0); end
      14: begin r = (m_b + 1) % MOD; co = (m_b == MASK); end
      default: begin r = (m_b + MASK) % MOD; co = (m_b == 0); end
    endcase
    sa = m_a >= MOD / 2; sb = m_b >= MOD / 2; sr = r >= MOD / 2;
    if (f == 4)      no = (sa == sb) && (sr != sa);
    else if (f == 5) no = (sa != sb) && (sr != sa);
    else             no = sr;
    if (ds) m_b = r; else m_a = r;
    m_c = co; m_n = no; m_z = (r == 0);
  endtask

  task automatic drive(input bit ae, input bit ds, input int f, input bit ce,
                       input int cm, input bit eb, input bit we, input bit ws,
                       input int wd, input string tag);
    exp_t e;
    @(negedge clk);
    alu_en = ae; dst_sel = ds; func = 4'(f); cmd_en = ce; cmd = 2'(cm);
    ext_bit = eb; wr_en = we; wr_sel = ws; wr_data = W'(wd);
    if (ae) model_alu(f, ds);
    else begin
      if (ce) case (cm)
        0: m_c = 0;
        1: m_c = 1;
        2: m_c = !m_c;
        default: m_c = eb;
      endcase
      if (we) begin if (ws) m_b = wd; else m_a = wd; end
    end
    e.a = m_a; e.b = m_b; e.c = m_c; e.n = m_n; e.z = m_z; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_load(input bit ws, input int v);
    drive(0, 0, 0, 0, 0, 0, 1, ws, v, "R11");
  endtask
  task automatic do_alu(input bit ds, input int f, input string tag);
    drive(1, ds, f, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic do_cmd(input int cm, input bit eb);
    drive(0, 0, 0, 1, cm, eb, 0, 0, 0, "R10");
  endtask
  task automatic idle(input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    exp_t r0;
    rst_n = 0; alu_en = 0; dst_sel = 0; func = 0; cmd_en = 0; cmd = 0;
    ext_bit = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);
    r0.a = 0; r0.b = 0; r0.c = 0; r0.n = 0; r0.z = 0; r0.tag = "R1";
    compare(r0);

    // R2 pass and complement, both destinations
    do_load(0, 'h5A); do_load(1, 'h3C);
    do_cmd(1, 0);
    do_alu(1, 0, "R2"); do_alu(0, 1, "R2"); do_alu(0, 2, "R2"); do_alu(1, 3, "R2");
    // R9 destination selection
    do_load(0, 'h11); do_load(1, 'h22);
    do_alu(0, 12, "R9"); do_alu(1, 14, "R9");
    // R3 add corners
    do_cmd(0, 0); do_load(0, 'h7F); do_load(1, 'h01); do_alu(0, 4, "R3");
    do_load(0, 'hFF); do_load(1, 'h01); do_alu(1, 4, "R3");
    do_alu(0, 4, "R3");
    // R4 subtract corners
    do_cmd(0, 0); do_load(0, 'h00); do_load(1, 'h01); do_alu(0, 5, "R4");
    do_load(0, 'h05); do_load(1, 'h03); do_cmd(1, 0); do_alu(0, 5, "R4");
    do_load(0, 'h80); do_load(1, 'h01); do_cmd(0, 0); do_alu(0, 5, "R4");
    // R5 logic
    do_cmd(1, 0); do_load(0, 'hF0); do_load(1, 'h0F);
    do_alu(1, 6, "R5"); do_load(1, 'h0F); do_alu(1, 7, "R5");
    // R6 rotates
    do_load(0, 'h01); do_alu(0, 8, "R6");
    do_load(0, 'h81); do_alu(0, 9, "R6");
    do_cmd(1, 0); do_load(0, 'h01); do_alu(0, 10, "R6");
    do_cmd(0, 0); do_load(0, 'h80); do_alu(0, 11, "R6");
    // R7 wrap points
    do_load(0, 'hFF); do_alu(0, 12, "R7");
    do_alu(0, 13, "R7");
    do_load(1, 'h00); do_alu(1, 15, "R7");
    do_alu(1, 14, "R7");
    // R8 zero and sign
    do_load(0, 'h00); do_alu(1, 0, "R8"); do_load(0, 'h80); do_alu(1, 0, "R8");
    // R10 carry commands
    do_cmd(1, 0); do_cmd(2, 0); do_cmd(2, 0); do_cmd(3, 0); do_cmd(3, 1); do_cmd(0, 1);
    // R12 priority
    do_load(0, 'h40); do_load(1, 'h02);
    drive(1, 0, 4, 1, 1, 1, 1, 1, 'hEE, "R12");
    drive(1, 1, 7, 1, 2, 0, 1, 0, 'h99, "R12");
    // R13 idle
    idle("R13"); idle("R13");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      int f;
      k = $urandom_range(0, 9);
      f = $urandom_range(0, 15);
      if (k < 6)      do_alu(1'($urandom_range(0, 1)), f, tag_of(f));
      else if (k < 7) do_load(1'($urandom_range(0, 1)), $urandom_range(0, MASK));
      else if (k < 8) do_cmd($urandom_range(0, 3), 1'($urandom_range(0, 1)));
      else if (k < 9) drive(1, 1'($urandom_range(0, 1)), f, 1, $urandom_range(0, 3),
                            1'($urandom_range(0, 1)), 1, 1'($urandom_range(0, 1)),
                            $urandom_range(0, MASK), "R12");
      else            drive(0, 0, 0, 1, $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                            1, 1'($urandom_range(0, 1)), $urandom_range(0, MASK), "R11");
    end
    idle("R13");
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule